// File: doc/BRIEF.md
# Write-Only Serial Host Byte Receiver with Length Framing

This block sits between a host's synchronous serial link and a display controller's command decoder and frame-memory writer. It samples the serial clock, data, chip-select and data/command select lines with the system clock, assembles bytes most significant bit first, and emits a one-cycle strobe with each completed byte, tagged as either display data or command. It cannot be read back: there are no data or status reads on this link.

A static strap selects one of two framing modes. In four-line mode a dedicated data/command line is sampled together with the eighth bit of each byte and sets that byte's tag. In three-line mode there is no such line. A two-byte length command, an opcode byte followed by a count byte L, announces that the next L+1 bytes are display data. The byte after that run is a command again. The block counts the remaining bytes of the run itself. Once a bit is lost, the only way back into byte alignment is the hardware reset, or a chip-select high phase, which restarts the bit count.

Top module: `srx_serial_rx`

## Requirements
- R1: After reset `byte_valid` is low and no strobe appears until eight serial clock rising edges have been received with chip select low.
- R2: Bits are taken on serial clock rising edges, first bit into bit 7 of `byte_data`, last bit into bit 0.
- R3: In four-line mode, `byte_is_data` equals the level of `ser_dc` at the eighth rising edge of the byte (1 = data, 0 = command). The level of `ser_dc` during the other seven bits has no effect.
- R4: Every eighth rising edge yields exactly one `byte_valid` pulse, one clock wide, without any further serial clock edge or closing command.
- R5: While `ser_cs_n` is high, serial clock edges are ignored and the bit count returns to zero, so a partial byte is discarded.
- R6: In three-line mode, byte 0xE8 received as a command is tagged command, and the following byte (count L) is tagged command. The next L+1 bytes are tagged data, and the byte after them is tagged command.
- R7: A count of 0x00 yields exactly one data byte, and 0xFF yields exactly 256.
- R8: In four-line mode, byte 0xE8 starts no data run: every tag follows `ser_dc`.
- R9: In three-line mode `ser_dc` has no effect on any tag.
- R10: In three-line mode, a value 0xE8 that falls inside a data run is tagged data and does not restart the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wire3_sel | input | 1 | Static strap: 1 = three-line length framing, 0 = four-line with data/command line |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_sck | input | 1 | Serial clock from host |
| ser_sda | input | 1 | Serial data from host |
| ser_dc | input | 1 | Data/command select (four-line mode only), 1 = data |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, valid with `byte_valid` |
| byte_is_data | output | 1 | Tag of the byte: 1 = display data, 0 = command |

## Verification
The hardest case to reach from the ports is the end of a long data run in three-line mode. The last of 256 data bytes must be tagged data, and the byte right after it must fall back to command. Reaching it takes a count of 0xFF and over two thousand serial bits. A directed stimulus drives the full run. Random stimulus adds many short runs whose data bytes include the length opcode, with the `ser_dc` line toggled at random, so the end of a run is crossed often. Partial bytes cut off by chip select, and clock edges sent while deselected, are mixed in before complete bytes to show that alignment recovers.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    FR_CMD  = 2'd0,
    FR_LEN  = 2'd1,
    FR_DATA = 2'd2
  } fr_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stg_q[s] <= d_i;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sda_i,
  input  logic              cs_n_i,
  input  logic              dc_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              dc_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              sck_q;
  logic              rise;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              done_q, done_n;
  logic              dc_q, dc_n;
  logic              sh_en;

  assign rise = sck_i & ~sck_q;

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    dc_n   = dc_q;
    sh_en  = 1'b0;
    if (cs_n_i) begin
      cnt_n = '0;
    end else if (rise) begin
      sh_en = 1'b1;
      sh_n  = {sh_q[WORD_W-2:0], sda_i};
      if (cnt_q == LAST_BIT) begin
        cnt_n  = '0;
        done_n = 1'b1;
        dc_n   = dc_i;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      dc_q   <= 1'b0;
    end else begin
      sck_q  <= sck_i;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      dc_q   <= dc_n;
      if (sh_en) begin
        sh_q <= sh_n;
      end
    end
  end

  assign bit_cnt_o = cnt_q;
  assign done_o    = done_q;
  assign word_o    = sh_q;
  assign dc_o      = dc_q;
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int                WORD_W     = 8,
  parameter int                LEN_W      = 8,
  parameter logic [WORD_W-1:0] LEN_OPCODE = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wire3_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              dc_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              is_data_o,
  output fr_state_e         state_o,
  output logic [LEN_W-1:0]  rem_o
);
  fr_state_e         st_q, st_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic              valid_q;
  logic [WORD_W-1:0] data_q;
  logic              tag_q, tag_n;

  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    tag_n = tag_q;
    if (!wire3_i) begin
      st_n = FR_CMD;
      if (done_i) begin
        tag_n = dc_i;
      end
    end else if (done_i) begin
      unique case (st_q)
        FR_CMD: begin
          tag_n = 1'b0;
          if (word_i == LEN_OPCODE) begin
            st_n = FR_LEN;
          end
        end
        FR_LEN: begin
          tag_n = 1'b0;
          rem_n = word_i[LEN_W-1:0];
          st_n  = FR_DATA;
        end
        FR_DATA: begin
          tag_n = 1'b1;
          if (rem_q == '0) begin
            st_n = FR_CMD;
          end else begin
            rem_n = rem_q - LEN_W'(1);
          end
        end
        default: begin
          tag_n = 1'b0;
          st_n  = FR_CMD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FR_CMD;
      rem_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      rem_q   <= rem_n;
      valid_q <= done_i;
      tag_q   <= tag_n;
      if (done_i) begin
        data_q <= word_i;
      end
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign is_data_o = tag_q;
  assign state_o   = st_q;
  assign rem_o     = rem_q;
endmodule

// File: rtl/srx_serial_rx.sv
module srx_serial_rx
  import srx_pkg::*;
#(
  parameter int                WORD_W      = 8,
  parameter int                LEN_W       = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] LEN_OPCODE  = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wire3_sel,
  input  logic              ser_cs_n,
  input  logic              ser_sck,
  input  logic              ser_sda,
  input  logic              ser_dc,
  output logic              byte_valid,
  output logic [WORD_W-1:0] byte_data,
  output logic              byte_is_data
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [3:0]        pins_s;
  logic              cs_n_s, sck_s, sda_s, dc_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              word_dc;
  fr_state_e         fr_state;
  logic [LEN_W-1:0]  fr_rem;

  srx_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_cs_n, ser_sck, ser_sda, ser_dc}),
    .q_o   (pins_s)
  );

  assign {cs_n_s, sck_s, sda_s, dc_s} = pins_s;

  srx_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_i     (sck_s),
    .sda_i     (sda_s),
    .cs_n_i    (cs_n_s),
    .dc_i      (dc_s),
    .bit_cnt_o (bit_cnt),
    .done_o    (word_done),
    .word_o    (word),
    .dc_o      (word_dc)
  );

  srx_framer #(
    .WORD_W     (WORD_W),
    .LEN_W      (LEN_W),
    .LEN_OPCODE (LEN_OPCODE)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .wire3_i   (wire3_sel),
    .done_i    (word_done),
    .word_i    (word),
    .dc_i      (word_dc),
    .valid_o   (byte_valid),
    .data_o    (byte_data),
    .is_data_o (byte_is_data),
    .state_o   (fr_state),
    .rem_o     (fr_rem)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import srx_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wire3_sel,
  input logic             cs_s,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             word_done,
  input logic             byte_valid,
  input fr_state_e        fr_state,
  input logic [LEN_W-1:0] fr_rem
);
  AST_CNT_CLEARED_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0)); // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R4

  AST_DONE_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> byte_valid); // R4

  AST_STROBE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(word_done)); // R4

  AST_FOUR_LINE_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !wire3_sel |=> (fr_state == FR_CMD)); // R8

  AST_RUN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wire3_sel && word_done && fr_state == FR_DATA && fr_rem != '0)
      |=> (fr_rem == $past(fr_rem) - {{(LEN_W-1){1'b0}}, 1'b1}) && (fr_state == FR_DATA)); // R6

  AST_RUN_ENDS_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wire3_sel && word_done && fr_state == FR_DATA && fr_rem == '0)
      |=> (fr_state == FR_CMD)); // R6
endmodule

bind srx_serial_rx srx_checker #(
  .CNT_W ($clog2(WORD_W)),
  .LEN_W (LEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wire3_sel  (wire3_sel),
  .cs_s       (cs_n_s),
  .bit_cnt    (bit_cnt),
  .word_done  (word_done),
  .byte_valid (byte_valid),
  .fr_state   (fr_state),
  .fr_rem     (fr_rem)
);

// File: tb/tb_srx_serial_rx.sv
`timescale 1ns/1ps
module tb_srx_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wire3_sel = 1'b0;
  logic       ser_cs_n = 1'b1;
  logic       ser_sck = 1'b0;
  logic       ser_sda = 1'b0;
  logic       ser_dc = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_is_data;

  always #4 clk = ~clk;

  srx_serial_rx dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wire3_sel    (wire3_sel),
    .ser_cs_n     (ser_cs_n),
    .ser_sck      (ser_sck),
    .ser_sda      (ser_sda),
    .ser_dc       (ser_dc),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_is_data (byte_is_data)
  );

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  logic [7:0] got_b [0:1023];
  logic       got_d [0:1023];
  int         got_n = 0;
  logic [7:0] exp_b [0:1023];
  logic       exp_d [0:1023];
  int         exp_n = 0;

  int         ms = 0;
  int         mrem = 0;

  always @(negedge clk) begin
    if (rst_n && byte_valid && got_n < 1024) begin
      got_b[got_n] = byte_data;
      got_d[got_n] = byte_is_data;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit model_tag(input logic [7:0] b, input logic dcv);
    bit t;
    if (!wire3_sel) return dcv;
    case (ms)
      0: begin t = 1'b0; if (b == 8'hE8) ms = 1; end
      1: begin t = 1'b0; mrem = int'(b); ms = 2; end
      default: begin t = 1'b1; if (mrem == 0) ms = 0; else mrem = mrem - 1; end
    endcase
    return t;
  endfunction

  task automatic clock_bit(input logic bitv);
    ser_sda = bitv;
    wait_clk(3);
    ser_sck = 1'b1;
    wait_clk(3);
    ser_sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic dcv);
    for (int i = 7; i >= 0; i--) begin
      ser_dc = (i == 0) ? dcv : logic'($urandom % 2);
      clock_bit(b[i]);
    end
    exp_b[exp_n] = b;
    exp_d[exp_n] = model_tag(b, dcv);
    exp_n++;
  endtask

  task automatic compare(input string req, input int start);
    wait_clk(12);
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int k = start; k < exp_n && k < got_n; k++) begin
      chk(got_b[k] == exp_b[k], req, int'(got_b[k]), int'(exp_b[k]));
      chk(got_d[k] == exp_d[k], req, int'(got_d[k]), int'(exp_d[k]));
    end
  endtask

  task automatic select(input logic m3);
    ser_cs_n = 1'b1;
    wait_clk(4);
    wire3_sel = m3;
    ms = 0;
    mrem = 0;
    wait_clk(4);
    ser_cs_n = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    int st;
    void'($urandom(32'd2024));
    wait_clk(5);
    rst_n = 1'b1;
    // R1: idle after reset, clock edges while deselected give nothing
    chk(byte_valid == 1'b0, "R1", int'(byte_valid), 0);
    for (int i = 0; i < 10; i++) clock_bit(1'b1);
    wait_clk(10);
    chk(got_n == 0, "R1", got_n, 0);

    // R2 R3 R4: four-line directed bit order and tags
    select(1'b0);
    st = exp_n;
    send_byte(8'h80, 1'b1);
    send_byte(8'h01, 1'b0);
    send_byte(8'hA5, 1'b1);
    compare("R2", st);

    // R8: length opcode in four-line mode, tags follow dc
    st = exp_n;
    send_byte(8'hE8, 1'b0);
    send_byte(8'h02, 1'b0);
    send_byte(8'h33, 1'b0);
    send_byte(8'h44, 1'b1);
    compare("R8", st);

    // R3 R4: random four-line traffic
    st = exp_n;
    for (int i = 0; i < 30; i++) send_byte(8'($urandom), logic'($urandom % 2));
    compare("R3", st);

    // R5: partial byte cut by deselect, edges while deselected
    st = exp_n;
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
    ser_cs_n = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 5; i++) clock_bit(1'b1);
    ser_cs_n = 1'b0;
    wait_clk(4);
    send_byte(8'h3C, 1'b1);
    compare("R5", st);

    // R6 R7 R9: three-line, count 0 gives one data byte
    select(1'b1);
    st = exp_n;
    send_byte(8'h12, 1'b1);
    send_byte(8'hE8, 1'b1);
    send_byte(8'h00, 1'b1);
    send_byte(8'h5A, 1'b0);
    send_byte(8'h77, 1'b1);
    compare("R7", st);

    // R10: opcode value inside a run stays data
    st = exp_n;
    send_byte(8'hE8, 1'b0);
    send_byte(8'h03, 1'b0);
    send_byte(8'hE8, 1'b0);
    send_byte(8'h01, 1'b0);
    send_byte(8'hE8, 1'b0);
    send_byte(8'h9F, 1'b0);
    send_byte(8'h21, 1'b1);
    compare("R10", st);

    // R7: count 0xFF gives 256 data bytes then a command
    st = exp_n;
    send_byte(8'hE8, 1'b0);
    send_byte(8'hFF, 1'b0);
    for (int i = 0; i < 256; i++) send_byte(8'($urandom), logic'($urandom % 2));
    send_byte(8'h0B, 1'b1);
    compare("R7", st);
    chk(exp_d[exp_n-2] == 1'b1 && exp_d[exp_n-1] == 1'b0, "R7", int'(exp_d[exp_n-1]), 0);

    // R6 R9 R10: random short runs
    st = exp_n;
    for (int r = 0; r < 8; r++) begin
      int len;
      logic [7:0] c;
      c = 8'($urandom);
      if (c == 8'hE8) c = 8'h00;
      send_byte(c, logic'($urandom % 2));
      len = int'($urandom % 6);
      send_byte(8'hE8, logic'($urandom % 2));
      send_byte(8'(len), logic'($urandom % 2));
      for (int i = 0; i <= len; i++)
        send_byte(((($urandom % 4) == 0) ? 8'hE8 : 8'($urandom)), logic'($urandom % 2));
    end
    send_byte(8'h44, 1'b1);
    compare("R6", st);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule